// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block runs a 12-bit parallel-output sampling converter on behalf of a host. A free-running interval timer, or a host start pulse, drives an active-low start-of-conversion pulse. The block then waits for the converter's active-low busy line to return high. It drives chip-select and read low together for a fixed number of cycles, and captures the result on the last cycle of that strobe.

The captured word is presented on a valid/ready output. An interrupt flag goes up when the conversion ends and drops when the host accepts the word. Triggers that arrive while the block is occupied are dropped and recorded in a sticky overrun flag.

The host can hold a sleep request. The block then enters power-down by driving the mode output low, with the read strobe parked high. It waits for any conversion in flight to be delivered first. When the request is released, mode returns high. The block at once runs one warm-up conversion whose result is thrown away, so N wanted samples after a wake cost N+1 conversions.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `cfg_period` = P > 0 and the block idle when each tick arrives, falling edges of `adc_convst_n` are spaced exactly P clock cycles apart. With P = 0, no timer-driven conversion occurs.
- R2: A one-cycle `host_start` pulse while idle and awake starts one conversion, and its result is delivered on `res_data`.
- R3: `adc_convst_n` stays low for exactly CONV_W consecutive cycles per conversion, and is never low together with `adc_rd_n`.
- R4: `adc_rd_n` is driven low only after `adc_busy_n` has returned high, and never while `adc_busy_n` is low.
- R5: `adc_cs_n` and `adc_rd_n` go low together for exactly RD_W cycles. The word captured is the value on `adc_data` in the last of those cycles, bits 11..0 carried unchanged.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` stays stable.
- R7: `irq` is high by the time `res_valid` rises, and it is low in the cycle after `res_valid` and `res_ready` are both high.
- R8: A trigger that arrives while a conversion, read or undelivered result is outstanding starts nothing. It sets `overrun`, which then stays high until reset.
- R9: While `sleep_req` is high and the block is idle, `adc_mode` is low and `adc_rd_n` is high, and triggers start nothing. A request made during a conversion takes effect only after the host has accepted that result.
- R10: When `sleep_req` falls, `adc_mode` goes high and one conversion starts at once without a trigger. Its result is not delivered, so N requested samples produce N+1 start pulses.
- R11: After reset, `adc_convst_n`, `adc_cs_n`, `adc_rd_n` and `adc_mode` are high, and `res_valid`, `irq` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_period | input | PER_W | Timer interval in cycles, 0 disables the timer |
| host_start | input | 1 | One-cycle host conversion request |
| sleep_req | input | 1 | Level: high requests power-down, low requests wake |
| adc_busy_n | input | 1 | Converter busy, low while converting |
| adc_data | input | DATA_W | Converter parallel output |
| adc_convst_n | output | 1 | Active-low start-of-conversion pulse |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read strobe |
| adc_mode | output | 1 | High for normal operation, low for power-down |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Host accepts the result |
| res_data | output | DATA_W | Captured result |
| irq | output | 1 | Interrupt flag for a pending result |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
The converter model returns a different word for every conversion, computed from its running index. It drives the inverted word on the data pins in every cycle except the last read cycle, so any capture made on the wrong cycle, and any lost or repeated sample, shows up as a mismatch. The timer is swept over a range of periods, and the spacing of start pulses is measured against each period; a zero period confirms that nothing fires. Host-started conversions are run with the host stalling, which separates handshake holding from free flow. The sleep sequences, immediate and deferred, compare the count of start pulses with the count of delivered words, which tells the warm-up conversion apart from a real sample. A final trigger into a pending result separates a dropped trigger from one that is queued.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion sequencer.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // awake, waiting for a trigger
        ST_CONV,   // start pulse low
        ST_WAIT,   // waiting for busy to return high
        ST_READ,   // chip-select and read strobe low
        ST_HOLD,   // result offered to host
        ST_SLEEP   // converter powered down
    } seq_state_t;
endpackage

// File: rtl/adc_seq_timer.sv
// Interval timer: emits a one-cycle tick every `period` cycles.
// Assumes period may change at any time; period 0 stops and clears it.
module adc_seq_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q;

    // Count up to period-1, wrap and pulse tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (period == '0) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= period - 1'b1) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_seq_edge.sv
// Synchronizer plus rising-edge detector for the converter busy line.
// Assumes the input idles high; output is a one-cycle pulse per rise.
module adc_seq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain; first stage samples the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage follows the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    // Remember the last synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencer: start pulse, end-of-conversion wait, timed read, result hold,
// power-down and post-wake discard. Assumes busy_rise is already synchronized.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CONV_W = 2,
    parameter int RD_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              sleep_req,
    input  logic              busy_rise,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              res_ready,
    output logic              convst_n,
    output logic              cs_n,
    output logic              rd_n,
    output logic              mode,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              irq,
    output logic              overrun
);
    localparam int MAX_W = (CONV_W > RD_W) ? CONV_W : RD_W;
    localparam int CNT_W = $clog2(MAX_W + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_W - 1);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_W - 1);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              discard_q;
    logic [DATA_W-1:0] data_q;
    logic              irq_q;
    logic              ovr_q;

    // Main sequencing: state, width counter, discard, capture and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            discard_q <= 1'b0;
            data_q    <= '0;
            irq_q     <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (trig && state_q != ST_IDLE && state_q != ST_SLEEP)
                ovr_q <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (sleep_req) begin
                        state_q <= ST_SLEEP;
                    end else if (trig) begin
                        state_q <= ST_CONV;
                        cnt_q   <= '0;
                    end
                end
                ST_CONV: begin
                    if (cnt_q == CONV_LAST) state_q <= ST_WAIT;
                    else                    cnt_q   <= cnt_q + 1'b1;
                end
                ST_WAIT: begin
                    if (busy_rise) begin
                        state_q <= ST_READ;
                        cnt_q   <= '0;
                        if (!discard_q) irq_q <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (cnt_q == RD_LAST) begin
                        if (discard_q) begin
                            discard_q <= 1'b0;
                            state_q   <= ST_IDLE;
                        end else begin
                            data_q  <= rd_data;
                            state_q <= ST_HOLD;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (res_ready) begin
                        irq_q   <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                ST_SLEEP: begin
                    if (!sleep_req) begin
                        discard_q <= 1'b1;
                        cnt_q     <= '0;
                        state_q   <= ST_CONV;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Converter pins and host outputs decoded from the registered state.
    assign convst_n  = (state_q != ST_CONV);
    assign cs_n      = (state_q != ST_READ);
    assign rd_n      = (state_q != ST_READ);
    assign mode      = (state_q != ST_SLEEP);
    assign res_valid = (state_q == ST_HOLD);
    assign res_data  = data_q;
    assign irq       = irq_q;
    assign overrun   = ovr_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top level: interval timer and host start feed the sequencer; the busy
// line is synchronized before use. Assumes one converter on private pins.
module adc_seq_ctrl #(
    parameter int DATA_W      = 12,
    parameter int PER_W       = 16,
    parameter int CONV_W      = 2,
    parameter int RD_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              host_start,
    input  logic              sleep_req,
    input  logic              adc_busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_convst_n,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              adc_mode,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              irq,
    output logic              overrun
);
    logic tmr_tick;
    logic busy_rise;

    adc_seq_timer #(.PER_W(PER_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (cfg_period),
        .tick   (tmr_tick)
    );

    adc_seq_edge #(.STAGES(SYNC_STAGES)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (adc_busy_n),
        .rise  (busy_rise)
    );

    adc_seq_fsm #(.DATA_W(DATA_W), .CONV_W(CONV_W), .RD_W(RD_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (tmr_tick | host_start),
        .sleep_req (sleep_req),
        .busy_rise (busy_rise),
        .rd_data   (adc_data),
        .res_ready (res_ready),
        .convst_n  (adc_convst_n),
        .cs_n      (adc_cs_n),
        .rd_n      (adc_rd_n),
        .mode      (adc_mode),
        .res_valid (res_valid),
        .res_data  (res_data),
        .irq       (irq),
        .overrun   (overrun)
    );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Property checker for the sequencer top, attached by bind below.
module adc_seq_ctrl_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_busy_n,
    input logic              adc_convst_n,
    input logic              adc_rd_n,
    input logic              adc_mode,
    input logic              res_valid,
    input logic              res_ready,
    input logic [DATA_W-1:0] res_data,
    input logic              irq,
    input logic              overrun
);
    p_convst_rd_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_convst_n |-> adc_rd_n);

    p_no_read_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> adc_busy_n);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> !irq);

    p_irq_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> irq);

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_sleep_rd_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_mode |-> adc_rd_n);

    p_wake_convert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_mode) |-> !adc_convst_n);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .adc_busy_n   (adc_busy_n),
    .adc_convst_n (adc_convst_n),
    .adc_rd_n     (adc_rd_n),
    .adc_mode     (adc_mode),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_data     (res_data),
    .irq          (irq),
    .overrun      (overrun)
);

// File: tb/adc_seq_ctrl_tb_top.sv
// Self-checking bench with a behavioural converter model.
module adc_seq_ctrl_tb_top;
    localparam int DATA_W = 12;
    localparam int PER_W  = 16;
    localparam int CONV_W = 2;
    localparam int RD_W   = 3;
    localparam int CONV_T = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PER_W-1:0]  cfg_period = '0;
    logic              host_start = 1'b0;
    logic              sleep_req = 1'b0;
    logic              busy_n = 1'b1;
    logic [DATA_W-1:0] adc_data;
    logic              adc_convst_n, adc_cs_n, adc_rd_n, adc_mode;
    logic              res_valid;
    logic              res_ready = 1'b0;
    logic [DATA_W-1:0] res_data;
    logic              irq, overrun;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_seq_ctrl #(.DATA_W(DATA_W), .PER_W(PER_W), .CONV_W(CONV_W), .RD_W(RD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .host_start(host_start),
        .sleep_req(sleep_req), .adc_busy_n(busy_n), .adc_data(adc_data),
        .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_mode(adc_mode), .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data), .irq(irq), .overrun(overrun)
    );

    function automatic logic [DATA_W-1:0] sample_val(input int k);
        return DATA_W'((k * 37 + 5) % 4096);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: busy low CONV_T cycles after a start edge; the true
    // word appears only on the last cycle of the read strobe.
    logic              prev_cv = 1'b1;
    int                remain = 0;
    int                conv_idx = 0;
    int                rd_run = 0;
    logic [DATA_W-1:0] cur_val = '0;

    always @(posedge clk) begin
        prev_cv <= adc_convst_n;
        rd_run  <= adc_rd_n ? 0 : rd_run + 1;
        if (prev_cv && !adc_convst_n) begin
            busy_n <= 1'b0;
            remain <= CONV_T;
        end else if (remain > 0) begin
            remain <= remain - 1;
            if (remain == 1) begin
                busy_n   <= 1'b1;
                cur_val  <= sample_val(conv_idx);
                conv_idx <= conv_idx + 1;
            end
        end
    end
    assign adc_data = (!adc_rd_n && rd_run == RD_W - 1) ? cur_val : ~cur_val;

    // Monitor: pulse widths, read legality, start spacing and scoreboard.
    int fall_cnt = 0;
    int last_fall = 0;
    int last_gap = 0;
    int cv_run = 0;
    int rdl_run = 0;
    int acc_cnt = 0;
    int exp_idx = 0;
    logic mon_prev_cv = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_prev_cv && !adc_convst_n) begin
                fall_cnt++;
                last_gap  = cyc - last_fall;
                last_fall = cyc;
            end
            mon_prev_cv = adc_convst_n;
            if (!adc_convst_n) begin
                cv_run++;
                chk(adc_rd_n == 1'b1, "R3 read during start", 0, 1);
            end else if (cv_run > 0) begin
                chk(cv_run == CONV_W, "R3 start width", cv_run, CONV_W);
                cv_run = 0;
            end
            if (!adc_rd_n) begin
                rdl_run++;
                chk(busy_n == 1'b1, "R4 read while busy", busy_n, 1);
                chk(adc_cs_n == 1'b0, "R5 cs with rd", adc_cs_n, 0);
            end else if (rdl_run > 0) begin
                chk(rdl_run == RD_W, "R5 read width", rdl_run, RD_W);
                rdl_run = 0;
            end
            if (!adc_mode)
                chk(adc_rd_n == 1'b1, "R9 rd high in sleep", adc_rd_n, 1);
            if (res_valid && res_ready) begin
                chk(res_data == sample_val(exp_idx), "R5 data", res_data, sample_val(exp_idx));
                exp_idx++;
                acc_cnt++;
            end
        end
    end

    task automatic tick_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 host_start = 1'b1;
        @(posedge clk); #1 host_start = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", cyc, 0);
            report();
        end
    end

    initial begin
        int f0;
        int a0;
        tick_n(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(adc_convst_n && adc_cs_n && adc_rd_n, "R11 strobes high", 0, 1);
        chk(adc_mode == 1'b1, "R11 mode", adc_mode, 1);
        chk(!res_valid && !irq && !overrun, "R11 flags low", {res_valid, irq, overrun}, 0);

        // R2/R6/R7: host start with the host stalling
        pulse_start();
        wait (res_valid);
        @(negedge clk);
        chk(res_data == sample_val(0), "R2 host start data", res_data, sample_val(0));
        chk(irq == 1'b1, "R7 irq with result", irq, 1);
        tick_n(5);
        @(negedge clk);
        chk(res_valid == 1'b1, "R6 valid held", res_valid, 1);
        chk(res_data == sample_val(0), "R6 data held", res_data, sample_val(0));
        @(posedge clk); #1 res_ready = 1'b1;
        @(posedge clk); #1 res_ready = 1'b0;
        @(negedge clk);
        chk(!res_valid && !irq, "R7 cleared on accept", {res_valid, irq}, 0);
        chk(overrun == 1'b0, "R8 no overrun yet", overrun, 0);

        // R1: timer sweep, free-flowing host
        res_ready = 1'b1;
        for (int p = 24; p <= 40; p += 4) begin
            f0 = fall_cnt;
            cfg_period = PER_W'(p);
            wait (fall_cnt == f0 + 1);
            for (int k = 2; k <= 4; k++) begin
                wait (fall_cnt == f0 + k);
                chk(last_gap == p, "R1 start spacing", last_gap, p);
            end
            cfg_period = '0;
            tick_n(40);
        end
        f0 = fall_cnt;
        tick_n(80);
        chk(fall_cnt == f0, "R1 period zero idle", fall_cnt - f0, 0);
        chk(acc_cnt == exp_idx && exp_idx == conv_idx, "R1 all results delivered", acc_cnt, conv_idx);

        // R9: immediate sleep, triggers ignored
        sleep_req = 1'b1;
        tick_n(3);
        @(negedge clk);
        chk(adc_mode == 1'b0, "R9 mode low", adc_mode, 0);
        f0 = fall_cnt;
        pulse_start();
        cfg_period = PER_W'(10);
        tick_n(30);
        cfg_period = '0;
        chk(fall_cnt == f0, "R9 no conversion asleep", fall_cnt - f0, 0);
        chk(overrun == 1'b0, "R9 no overrun asleep", overrun, 0);

        // R10: wake, warm-up discarded, then 3 samples cost 4 starts
        a0 = acc_cnt;
        exp_idx = exp_idx + 1;
        sleep_req = 1'b0;
        tick_n(40);
        chk(adc_mode == 1'b1, "R10 mode high", adc_mode, 1);
        chk(fall_cnt == f0 + 1, "R10 warm-up start", fall_cnt - f0, 1);
        chk(acc_cnt == a0, "R10 warm-up not delivered", acc_cnt - a0, 0);
        for (int n = 0; n < 3; n++) begin
            pulse_start();
            tick_n(30);
        end
        chk(fall_cnt - f0 == 4, "R10 N+1 starts", fall_cnt - f0, 4);
        chk(acc_cnt - a0 == 3, "R10 N results", acc_cnt - a0, 3);

        // R9: deferred sleep during conversion
        res_ready = 1'b0;
        pulse_start();
        tick_n(2);
        sleep_req = 1'b1;
        wait (res_valid);
        tick_n(3);
        @(negedge clk);
        chk(adc_mode == 1'b1, "R9 sleep deferred", adc_mode, 1);
        @(posedge clk); #1 res_ready = 1'b1;
        @(posedge clk); #1 res_ready = 1'b0;
        tick_n(3);
        @(negedge clk);
        chk(adc_mode == 1'b0, "R9 sleep after accept", adc_mode, 0);
        f0 = fall_cnt;
        a0 = acc_cnt;
        exp_idx = exp_idx + 1;
        sleep_req = 1'b0;
        tick_n(40);
        chk(fall_cnt - f0 == 1 && acc_cnt == a0, "R10 second warm-up", fall_cnt - f0, 1);

        // R8: trigger into a pending result
        res_ready = 1'b0;
        pulse_start();
        wait (res_valid);
        @(negedge clk);
        chk(overrun == 1'b0, "R8 clean before", overrun, 0);
        f0 = fall_cnt;
        pulse_start();
        @(negedge clk);
        chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
        @(posedge clk); #1 res_ready = 1'b1;
        @(posedge clk); #1 res_ready = 1'b0;
        tick_n(30);
        chk(fall_cnt == f0, "R8 trigger dropped", fall_cnt - f0, 0);
        chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
        chk(!res_valid, "R8 no queued result", res_valid, 0);

        done = 1'b1;
        report();
    end
endmodule